// File: doc/BRIEF.md
# Fixed-Slot Video and Context Timing Generator

This block runs on the machine-cycle clock (nominally 8.25 MHz, a 33 MHz oscillator divided by four) and carves time into fixed slots of 43 cycles, about 192 kHz of slots. Five slots make one video line (about 38.4 kHz). Four lines make one block (about 9593 per second), which also serves as the bit time of a 9600 baud serial link and the sample period of 9.6 kHz audio. One hundred and sixty blocks make one frame of about 60 Hz.

Each line opens with a sync slot, during which an active-low horizontal sync is driven. The first line of every block also carries one housekeeping slot that follows the sync slot. Every other slot is free for interpreted code, which leaves 15 code slots per block. The slot-type code tells the software engine what to run in the current slot. A context number picks the virtual CPU served in each block. Three fixed contexts take the first three blocks of a group of four, and the fourth block cycles through four further contexts, one per group.

Pixel output, the interpreter, the serial shifter and the audio converter sit outside this block and use its outputs.

Top module: `slot_timing_gen`

## Requirements
- R1: While `rst` is high, `hsync_n` is 1 and `block_tick` and `frame_tick` are 0. The first cycle after `rst` falls is cycle 0 of slot 0, line 0, block 0 and rotation step 0, so both ticks are 1, `hsync_n` is 0 and `ctx_id` is 1 in that cycle.
- R2: Every slot lasts exactly 43 cycles, and `slot_kind` holds its value for the whole slot.
- R3: A line is 5 slots. Slot 0 of every line has `slot_kind` = 0 (sync), and `hsync_n` is 0 for exactly those 43 cycles and 1 at all other times.
- R4: Slot 1 of line 0 of every block has `slot_kind` = 1 (housekeeping). Every other slot has `slot_kind` = 2 (code), which gives 15 code slots per block. The value 3 never appears.
- R5: `block_tick` is a one-cycle pulse on the first cycle of every block, that is, every 4 × 5 × 43 = 860 cycles, starting with the first cycle after reset.
- R6: `frame_tick` is a one-cycle pulse on the first cycle of every 160th block (every 137600 cycles), and it always falls in a cycle where `block_tick` is also 1.
- R7: For block number n counted from reset, `ctx_id` is n mod 4 + 1 when n mod 4 < 3. Otherwise it is 4 + ((n div 4) mod 4), which gives 1,2,3,4, 1,2,3,5, 1,2,3,6, 1,2,3,7, and the sequence repeats. `ctx_id` changes only in a cycle where `block_tick` is 1.
- R8: Asserting `rst` at any point, including the last cycle of a slot or mid-block, restarts all counting so that the cycle after release again behaves as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | output | 1 | Horizontal sync, low for the whole sync slot |
| block_tick | output | 1 | One-cycle pulse at the start of each block |
| frame_tick | output | 1 | One-cycle pulse at the start of each frame |
| slot_kind | output | 2 | 0 = sync, 1 = block housekeeping, 2 = code |
| ctx_id | output | 3 | Virtual CPU context for the current block |

## Verification
The frame tick, the block tick, the start of a sync slot and a step of the context rotation all fall on the same cycle at the start of a frame. A mid-run reset can also land on a slot's last cycle, where the counters would otherwise wrap. A directed run of more than one full frame carries the counters across the wrap from block 159 to block 0. At that cycle all four outputs are compared with values computed from the cycle count since reset. Random reset pulses at random offsets, some of them placed on a slot's final cycle, then check that every count restarts cleanly, whatever position the reset interrupted.

// File: rtl/slot_timing_pkg.sv
package slot_timing_pkg;

    localparam int unsigned DEF_SLOT_CYC   = 43;
    localparam int unsigned DEF_SLOTS_LINE = 5;
    localparam int unsigned DEF_LINES_BLK  = 4;
    localparam int unsigned DEF_BLKS_FRAME = 160;
    localparam int unsigned DEF_FIXED_CTX  = 3;
    localparam int unsigned DEF_ROT_CTX    = 4;
    localparam int unsigned CTX_W          = 3;

    typedef enum logic [1:0] {
        SK_SYNC  = 2'd0,
        SK_HOUSE = 2'd1,
        SK_CODE  = 2'd2
    } slot_kind_e;

    // Which slot type occupies a given slot of a given line.
    function automatic slot_kind_e kind_of(input logic slot_is_zero,
                                           input logic slot_is_one,
                                           input logic line_is_zero);
        if (slot_is_zero)
            return SK_SYNC;
        else if (slot_is_one && line_is_zero)
            return SK_HOUSE;
        else
            return SK_CODE;
    endfunction

endpackage

// File: rtl/slot_cycle_ctr.sv
module slot_cycle_ctr #(
    parameter int unsigned SLOT_CYC   = 43,
    parameter int unsigned SLOTS_LINE = 5,
    localparam int unsigned CYC_W  = $clog2(SLOT_CYC),
    localparam int unsigned SLOT_W = (SLOTS_LINE > 1) ? $clog2(SLOTS_LINE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [CYC_W-1:0]  cyc,
    output logic [SLOT_W-1:0] slot,
    output logic              line_start,
    output logic              line_end
);
    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_CYC - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS_LINE - 1);

    logic slot_end;

    assign slot_end   = (cyc == CYC_LAST);
    assign line_end   = slot_end && (slot == SLOT_LAST);
    assign line_start = (cyc == '0) && (slot == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc  <= '0;
            slot <= '0;
        end else if (slot_end) begin
            cyc  <= '0;
            slot <= line_end ? '0 : slot + 1'b1;
        end else begin
            cyc  <= cyc + 1'b1;
        end
    end

    AST_CYC_BOUND: assert property (@(posedge clk) disable iff (rst)
        cyc <= CYC_LAST); // R2
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cyc != CYC_LAST) |=> $stable(slot)); // R2
    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
        slot <= SLOT_LAST); // R3

endmodule

// File: rtl/line_block_ctr.sv
module line_block_ctr #(
    parameter int unsigned LINES_BLK  = 4,
    parameter int unsigned BLKS_FRAME = 160,
    localparam int unsigned LINE_W = (LINES_BLK > 1) ? $clog2(LINES_BLK) : 1,
    localparam int unsigned BLK_W  = (BLKS_FRAME > 1) ? $clog2(BLKS_FRAME) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    output logic [LINE_W-1:0] line,
    output logic [BLK_W-1:0]  blk,
    output logic              block_end
);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_BLK - 1);
    localparam logic [BLK_W-1:0]  BLK_LAST  = BLK_W'(BLKS_FRAME - 1);

    assign block_end = line_end && (line == LINE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= '0;
            blk  <= '0;
        end else if (line_end) begin
            line <= block_end ? '0 : line + 1'b1;
            if (block_end)
                blk <= (blk == BLK_LAST) ? '0 : blk + 1'b1;
        end
    end

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(line)); // R3
    AST_BLK_BOUND: assert property (@(posedge clk) disable iff (rst)
        blk <= BLK_LAST); // R6

endmodule

// File: rtl/ctx_rotator.sv
module ctx_rotator #(
    parameter int unsigned FIXED_CTX = 3,
    parameter int unsigned ROT_CTX   = 4,
    parameter int unsigned CTX_BITS  = 3,
    localparam int unsigned POS_W  = $clog2(FIXED_CTX + 1),
    localparam int unsigned STEP_W = (ROT_CTX > 1) ? $clog2(ROT_CTX) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                block_end,
    output logic [CTX_BITS-1:0] ctx_id
);
    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(FIXED_CTX);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(ROT_CTX - 1);

    logic [POS_W-1:0]  pos;
    logic [STEP_W-1:0] step;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            step <= '0;
        end else if (block_end) begin
            if (pos == POS_LAST) begin
                pos  <= '0;
                step <= (step == STEP_LAST) ? '0 : step + 1'b1;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    always_comb begin
        if (pos < POS_LAST)
            ctx_id = CTX_BITS'(pos) + CTX_BITS'(1);
        else
            ctx_id = CTX_BITS'(FIXED_CTX + 1) + CTX_BITS'(step);
    end

    AST_CTX_NONZERO: assert property (@(posedge clk) disable iff (rst)
        ctx_id != '0); // R7
    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pos != POS_LAST) |=> $stable(step)); // R7

endmodule

// File: rtl/slot_timing_gen.sv
module slot_timing_gen
    import slot_timing_pkg::*;
#(
    parameter int unsigned SLOT_CYC   = DEF_SLOT_CYC,
    parameter int unsigned SLOTS_LINE = DEF_SLOTS_LINE,
    parameter int unsigned LINES_BLK  = DEF_LINES_BLK,
    parameter int unsigned BLKS_FRAME = DEF_BLKS_FRAME,
    parameter int unsigned FIXED_CTX  = DEF_FIXED_CTX,
    parameter int unsigned ROT_CTX    = DEF_ROT_CTX
) (
    input  logic             clk,
    input  logic             rst,
    output logic             hsync_n,
    output logic             block_tick,
    output logic             frame_tick,
    output logic [1:0]       slot_kind,
    output logic [CTX_W-1:0] ctx_id
);
    localparam int unsigned CYC_W  = $clog2(SLOT_CYC);
    localparam int unsigned SLOT_W = (SLOTS_LINE > 1) ? $clog2(SLOTS_LINE) : 1;
    localparam int unsigned LINE_W = (LINES_BLK > 1) ? $clog2(LINES_BLK) : 1;
    localparam int unsigned BLK_W  = (BLKS_FRAME > 1) ? $clog2(BLKS_FRAME) : 1;

    logic [CYC_W-1:0]  cyc;
    logic [SLOT_W-1:0] slot;
    logic [LINE_W-1:0] line;
    logic [BLK_W-1:0]  blk;
    logic              line_start, line_end, block_end;
    slot_kind_e        kind;

    slot_cycle_ctr #(.SLOT_CYC(SLOT_CYC), .SLOTS_LINE(SLOTS_LINE)) u_slot (
        .clk(clk), .rst(rst), .cyc(cyc), .slot(slot),
        .line_start(line_start), .line_end(line_end)
    );

    line_block_ctr #(.LINES_BLK(LINES_BLK), .BLKS_FRAME(BLKS_FRAME)) u_blk (
        .clk(clk), .rst(rst), .line_end(line_end),
        .line(line), .blk(blk), .block_end(block_end)
    );

    ctx_rotator #(.FIXED_CTX(FIXED_CTX), .ROT_CTX(ROT_CTX), .CTX_BITS(CTX_W)) u_ctx (
        .clk(clk), .rst(rst), .block_end(block_end), .ctx_id(ctx_id)
    );

    assign kind       = kind_of(slot == '0, slot == SLOT_W'(1), line == '0);
    assign slot_kind  = kind;
    assign hsync_n    = rst || (kind != SK_SYNC);
    assign block_tick = !rst && line_start && (line == '0);
    assign frame_tick = block_tick && (blk == '0);

    AST_FRAME_ON_BLOCK: assert property (@(posedge clk) disable iff (rst)
        frame_tick |-> block_tick); // R6
    AST_TICK_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        block_tick |-> !hsync_n); // R5
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        block_tick |=> !block_tick); // R5
    AST_CTX_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (rst)
        !block_tick |-> $stable(ctx_id)); // R7
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        slot_kind != 2'd3); // R4

endmodule

// File: tb/test_slot_timing_gen.sv
module test_slot_timing_gen;

    localparam int unsigned SC = 43;
    localparam int unsigned SL = 5;
    localparam int unsigned LB = 4;
    localparam int unsigned BF = 160;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_n, block_tick, frame_tick;
    logic [1:0] slot_kind;
    logic [2:0] ctx_id;

    int unsigned k = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    slot_timing_gen i_slot_timing_gen (
        .clk(clk), .rst(rst), .hsync_n(hsync_n), .block_tick(block_tick),
        .frame_tick(frame_tick), .slot_kind(slot_kind), .ctx_id(ctx_id)
    );

    always @(posedge clk) k <= rst ? 0 : k + 1;

    function automatic logic [1:0] exp_kind(input int unsigned kk);
        int unsigned sn = kk / SC;
        if (sn % SL == 0) return 2'd0;
        if (sn % SL == 1 && (sn / SL) % LB == 0) return 2'd1;
        return 2'd2;
    endfunction

    function automatic logic [2:0] exp_ctx(input int unsigned kk);
        int unsigned b = kk / (SC * SL * LB);
        if (b % 4 < 3) return 3'(b % 4 + 1);
        return 3'(4 + (b / 4) % 4);
    endfunction

    task automatic cmp(input string req, input int unsigned act, input int unsigned exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at k=%0d: actual %0d expected %0d", req, k, act, exp);
        end
    endtask

    task automatic check_now();
        int unsigned blen = SC * SL * LB;
        if (rst) begin
            cmp("R1 hsync_n in reset", hsync_n, 1);
            cmp("R1 block_tick in reset", block_tick, 0);
            cmp("R1 frame_tick in reset", frame_tick, 0);
        end else begin
            cmp("R3 hsync_n", hsync_n, exp_kind(k) != 2'd0);
            cmp("R2/R4 slot_kind", slot_kind, exp_kind(k));
            cmp("R5 block_tick", block_tick, (k % blen) == 0);
            cmp("R6 frame_tick", frame_tick, (k % (blen * BF)) == 0);
            cmp("R7 ctx_id", ctx_id, exp_ctx(k));
            if (k == 0) cmp("R1 ctx after reset", ctx_id, 1);
        end
    endtask

    task automatic tick(input logic r);
        @(negedge clk);
        check_now();
        rst = r;
    endtask

    initial begin
        void'($urandom(32'd20250));
        tick(1'b1);
        tick(1'b1);
        tick(1'b0);
        // R6: run past the first frame wrap
        for (int i = 0; i < 138500; i++) tick(1'b0);
        // R8: reset on the last cycle of a slot
        while ((k % SC) != SC - 2) tick(1'b0);
        tick(1'b1);
        tick(1'b0);
        for (int i = 0; i < 3000; i++) tick(1'b0);
        // R8: random reset points and lengths
        for (int j = 0; j < 10; j++) begin
            int unsigned run = $urandom_range(200, 4000);
            int unsigned hold = $urandom_range(1, 3);
            for (int i = 0; i < int'(run); i++) tick(1'b0);
            for (int i = 0; i < int'(hold); i++) tick(1'b1);
            tick(1'b0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 195000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule